// File: doc/BRIEF.md
# Address Generator with Alignment Check

This block produces load and store addresses from three small register files: index registers, modifier registers and pointer registers. An index register is stepped by a modifier register. A pointer register is stepped by another pointer register, which may be the same one. The step can be issued on its own as a modify operation. It can also be folded into a memory access as a post-modify: memory sees the old value and the register takes the sum at the same clock edge.

Every access is checked against its size. A 16-bit access must be even. A 32-bit access must sit on a four-byte boundary. A misaligned access raises a one-cycle exception pulse. Two things can silence that pulse: a per-access suppress flag, and a dedicated opcode for accesses that are allowed to be unaligned. Software loads the registers with a write operation and can read any register back at any time through a separate combinational read port.

Top module: `addr_gen`

## Requirements
- R1: While rst_ni is low, every register is cleared. After reset, readback of every register is 0, align_exc_o is 0 and addr_o is 0.
- R2: When op_valid_i is high, opcode 1 (write) loads wdata_i into register dst_sel_i of file file_i at the clock edge. File codes are 0 index (4 entries), 1 modifier (4 entries) and 2 pointer (6 entries). rdata_o shows register rd_sel_i of file rd_file_i combinationally, and shows 0 for file code 3 or for an out-of-range select.
- R3: Opcode 2 (modify) with file_i=0 adds modifier register mod_sel_i to index register dst_sel_i and writes the sum back. The sum wraps modulo 2^32.
- R4: Opcode 2 with file_i=2 adds pointer register mod_sel_i to pointer register dst_sel_i and writes the sum back. mod_sel_i may equal dst_sel_i.
- R5: Three opcodes are accesses: 3 (plain access), 4 (access with post-modify) and 5 (unchecked access). After the edge that performs an access, addr_o holds the selected register's value from before that edge. Opcode 3 leaves the register unchanged. Opcode 4 updates it in the same way as R3 and R4. Between accesses, addr_o keeps its value.
- R6: size_i codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, and 3, which is treated as 8-bit. A 32-bit access is misaligned when address bits [1:0] are nonzero. A 16-bit access is misaligned when bit 0 is 1. An 8-bit access is never misaligned.
- R7: A misaligned access drives align_exc_o high for exactly the cycle after its edge. A post-modify register update still happens when the exception is raised.
- R8: An access issued with suppress_i=1 never raises align_exc_o.
- R9: Opcode 5 never raises align_exc_o and never updates a register.
- R10: Some operations have no effect on any register, on addr_o or on align_exc_o:
  - any operation with op_valid_i=0;
  - opcodes 0, 6 and 7;
  - a modify or access with file_i=1 or 3;
  - an operation whose dst_sel_i, or whose needed mod_sel_i, is out of range for its file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation valid this cycle |
| op_i | input | 3 | Opcode: 0 idle, 1 write, 2 modify, 3 access, 4 access+post-modify, 5 unchecked access |
| file_i | input | 2 | Target file: 0 index, 1 modifier, 2 pointer |
| dst_sel_i | input | 3 | Register select in the target file |
| mod_sel_i | input | 3 | Modifier select (modifier file for index, pointer file for pointer) |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| suppress_i | input | 1 | Suppress alignment exception for this access |
| wdata_i | input | 32 | Write data for opcode 1 |
| rd_file_i | input | 2 | Readback file select |
| rd_sel_i | input | 3 | Readback register select |
| addr_o | output | 32 | Effective address of the most recent access |
| align_exc_o | output | 1 | Alignment exception pulse |
| rdata_o | output | 32 | Register readback |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that a post-modify sum is meant to wrap. The bench drives every input on the falling edge and samples results one nanosecond after the rising edge, so each operation is seen exactly once. Opcodes, file codes and selects that fall outside their legal ranges appear only in the directed tests that check R10.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_WRITE      = 3'd1,
    OP_MODIFY     = 3'd2,
    OP_ACCESS     = 3'd3,
    OP_ACCESS_PM  = 3'd4,
    OP_ACCESS_RAW = 3'd5
  } agu_op_e;

  typedef enum logic [1:0] {
    FILE_IDX  = 2'd0,
    FILE_MOD  = 2'd1,
    FILE_PTR  = 2'd2,
    FILE_NONE = 2'd3
  } agu_file_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_RSV = 2'd3
  } agu_size_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wsel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] regs_o [N]
);
  localparam logic [SW:0] LIM = (SW+1)'(N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_o[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N; i++)
        if (wsel_i == SW'(i)) regs_o[i] <= wdata_i;
    end
  end

  // decode in the parent must never target a missing entry
  p_wsel_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ({1'b0, wsel_i} < LIM));
endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk
  import addr_gen_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lsb_i,
  output logic       misaligned_o
);
  always_comb begin
    unique case (size_i)
      SZ_16:   misaligned_o = addr_lsb_i[0];
      SZ_32:   misaligned_o = |addr_lsb_i;
      default: misaligned_o = 1'b0;
    endcase
  end

  always_comb begin
    if (addr_lsb_i == 2'b00)
      p_aligned_ok_r6: assert (!misaligned_o);
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import addr_gen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int N_IDX = 4,
  parameter int N_MOD = 4,
  parameter int N_PTR = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    file_i,
  input  logic [2:0]    dst_sel_i,
  input  logic [2:0]    mod_sel_i,
  input  logic [1:0]    size_i,
  input  logic          suppress_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [1:0]    rd_file_i,
  input  logic [2:0]    rd_sel_i,
  output logic [AW-1:0] addr_o,
  output logic          align_exc_o,
  output logic [AW-1:0] rdata_o
);
  localparam int SW = 3;
  localparam logic [SW:0] LIM_I = (SW+1)'(N_IDX);
  localparam logic [SW:0] LIM_M = (SW+1)'(N_MOD);
  localparam logic [SW:0] LIM_P = (SW+1)'(N_PTR);

  logic [AW-1:0] idx_q [N_IDX];
  logic [AW-1:0] mod_q [N_MOD];
  logic [AW-1:0] ptr_q [N_PTR];

  logic is_acc, is_upd, is_wr;
  logic base_ok, mod_ok, wr_ok;
  logic acc_act, upd_act, wr_act;
  logic [AW-1:0] base_val, mod_val, sum;
  logic misaligned;
  logic idx_we, mod_we, ptr_we;
  logic [AW-1:0] reg_wdata;
  logic [AW-1:0] addr_q;
  logic exc_q;

  // opcode classes
  always_comb begin
    is_wr  = (op_i == OP_WRITE);
    is_acc = (op_i == OP_ACCESS) || (op_i == OP_ACCESS_PM) || (op_i == OP_ACCESS_RAW);
    is_upd = (op_i == OP_MODIFY) || (op_i == OP_ACCESS_PM);
  end

  // legality of selects per file
  always_comb begin
    base_ok = 1'b0;
    mod_ok  = 1'b0;
    wr_ok   = 1'b0;
    unique case (file_i)
      FILE_IDX: begin
        base_ok = {1'b0, dst_sel_i} < LIM_I;
        mod_ok  = {1'b0, mod_sel_i} < LIM_M;
        wr_ok   = base_ok;
      end
      FILE_PTR: begin
        base_ok = {1'b0, dst_sel_i} < LIM_P;
        mod_ok  = {1'b0, mod_sel_i} < LIM_P;
        wr_ok   = base_ok;
      end
      FILE_MOD: wr_ok = {1'b0, dst_sel_i} < LIM_M;
      default: ;
    endcase
  end

  always_comb begin
    wr_act  = op_valid_i && is_wr && wr_ok;
    acc_act = op_valid_i && is_acc && base_ok && (op_i != OP_ACCESS_PM || mod_ok);
    upd_act = op_valid_i && is_upd && base_ok && mod_ok;
  end

  // base and modifier operands; index steps by M, pointer steps by P
  always_comb begin
    base_val = '0;
    mod_val  = '0;
    if (file_i == FILE_IDX) begin
      for (int i = 0; i < N_IDX; i++) if (dst_sel_i == SW'(i)) base_val = idx_q[i];
      for (int i = 0; i < N_MOD; i++) if (mod_sel_i == SW'(i)) mod_val = mod_q[i];
    end else if (file_i == FILE_PTR) begin
      for (int i = 0; i < N_PTR; i++) if (dst_sel_i == SW'(i)) base_val = ptr_q[i];
      for (int i = 0; i < N_PTR; i++) if (mod_sel_i == SW'(i)) mod_val = ptr_q[i];
    end
  end

  assign sum = base_val + mod_val;

  always_comb begin
    reg_wdata = wr_act ? wdata_i : sum;
    idx_we = (wr_act || upd_act) && (file_i == FILE_IDX);
    ptr_we = (wr_act || upd_act) && (file_i == FILE_PTR);
    mod_we = wr_act && (file_i == FILE_MOD);
  end

  agu_regfile #(.N(N_IDX), .DW(AW), .SW(SW)) u_idx (
    .clk_i, .rst_ni, .we_i(idx_we), .wsel_i(dst_sel_i), .wdata_i(reg_wdata), .regs_o(idx_q));
  agu_regfile #(.N(N_MOD), .DW(AW), .SW(SW)) u_mod (
    .clk_i, .rst_ni, .we_i(mod_we), .wsel_i(dst_sel_i), .wdata_i(reg_wdata), .regs_o(mod_q));
  agu_regfile #(.N(N_PTR), .DW(AW), .SW(SW)) u_ptr (
    .clk_i, .rst_ni, .we_i(ptr_we), .wsel_i(dst_sel_i), .wdata_i(reg_wdata), .regs_o(ptr_q));

  agu_align_chk u_align (
    .size_i(size_i), .addr_lsb_i(base_val[1:0]), .misaligned_o(misaligned));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      exc_q  <= 1'b0;
    end else begin
      exc_q <= acc_act && misaligned && !suppress_i && (op_i != OP_ACCESS_RAW);
      if (acc_act) addr_q <= base_val;
    end
  end

  assign addr_o      = addr_q;
  assign align_exc_o = exc_q;

  // readback
  always_comb begin
    rdata_o = '0;
    unique case (rd_file_i)
      FILE_IDX: for (int i = 0; i < N_IDX; i++) if (rd_sel_i == SW'(i)) rdata_o = idx_q[i];
      FILE_MOD: for (int i = 0; i < N_MOD; i++) if (rd_sel_i == SW'(i)) rdata_o = mod_q[i];
      FILE_PTR: for (int i = 0; i < N_PTR; i++) if (rd_sel_i == SW'(i)) rdata_o = ptr_q[i];
      default: ;
    endcase
  end

  p_suppress_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && is_acc && suppress_i) |=> !align_exc_o);
  p_raw_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_ACCESS_RAW) |=> !align_exc_o);
  p_byte_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && is_acc && (size_i == SZ_8 || size_i == SZ_RSV)) |=> !align_exc_o);
  p_exc_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_exc_o |-> $past(op_valid_i && is_acc));
  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && is_acc) |=> $stable(addr_o));
endmodule

// File: tb/addr_gen_bench.sv
`timescale 1ns/1ps
module addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  file_i = '0;
  logic [2:0]  dst_sel_i = '0, mod_sel_i = '0;
  logic [1:0]  size_i = '0;
  logic        suppress_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  rd_file_i = '0;
  logic [2:0]  rd_sel_i = '0;
  logic [31:0] addr_o, rdata_o;
  logic        align_exc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_gen u_addr_gen (
    .clk_i(clk), .rst_ni, .op_valid_i, .op_i, .file_i, .dst_sel_i, .mod_sel_i,
    .size_i, .suppress_i, .wdata_i, .rd_file_i, .rd_sel_i,
    .addr_o, .align_exc_o, .rdata_o);

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  fl;
    logic [2:0]  dst;
    logic [2:0]  md;
    logic [1:0]  sz;
    logic        sp;
    logic [31:0] wd;
    logic [31:0] exp_addr;
    logic        exp_exc;
    logic [15:0] tag;
  } vec_t;

  // op: 1 wr 2 mod 3 acc 4 acc+pm 5 raw; file 0 I 1 M 2 P; size 0 b 1 h 2 w
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 2'd0, 3'd0, 3'd0, 2'd0, 1'b0, 32'h1000_0001, 32'h0000_0000, 1'b0, "R2"},
    '{3'd1, 2'd1, 3'd1, 3'd0, 2'd0, 1'b0, 32'h0000_0003, 32'h0000_0000, 1'b0, "R2"},
    '{3'd1, 2'd2, 3'd2, 3'd0, 2'd0, 1'b0, 32'h2000_0002, 32'h0000_0000, 1'b0, "R2"},
    '{3'd1, 2'd2, 3'd5, 3'd0, 2'd0, 1'b0, 32'hFFFF_FFFE, 32'h0000_0000, 1'b0, "R2"},
    '{3'd3, 2'd0, 3'd0, 3'd0, 2'd2, 1'b0, 32'h0,         32'h1000_0001, 1'b1, "R6"},
    '{3'd4, 2'd0, 3'd0, 3'd1, 2'd1, 1'b0, 32'h0,         32'h1000_0001, 1'b1, "R7"},
    '{3'd3, 2'd0, 3'd0, 3'd0, 2'd2, 1'b0, 32'h0,         32'h1000_0004, 1'b0, "R5"},
    '{3'd3, 2'd2, 3'd2, 3'd0, 2'd2, 1'b0, 32'h0,         32'h2000_0002, 1'b1, "R6"},
    '{3'd3, 2'd2, 3'd2, 3'd0, 2'd1, 1'b0, 32'h0,         32'h2000_0002, 1'b0, "R6"},
    '{3'd3, 2'd2, 3'd2, 3'd0, 2'd2, 1'b1, 32'h0,         32'h2000_0002, 1'b0, "R8"},
    '{3'd5, 2'd2, 3'd2, 3'd0, 2'd2, 1'b0, 32'h0,         32'h2000_0002, 1'b0, "R9"},
    '{3'd2, 2'd2, 3'd2, 3'd5, 2'd0, 1'b0, 32'h0,         32'h2000_0002, 1'b0, "R4"},
    '{3'd3, 2'd2, 3'd2, 3'd0, 2'd2, 1'b0, 32'h0,         32'h2000_0000, 1'b0, "R4"},
    '{3'd1, 2'd0, 3'd3, 3'd0, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h2000_0000, 1'b0, "R2"},
    '{3'd1, 2'd1, 3'd3, 3'd0, 2'd0, 1'b0, 32'h0000_0002, 32'h2000_0000, 1'b0, "R2"},
    '{3'd2, 2'd0, 3'd3, 3'd3, 2'd0, 1'b0, 32'h0,         32'h2000_0000, 1'b0, "R3"},
    '{3'd3, 2'd0, 3'd3, 3'd0, 2'd0, 1'b0, 32'h0,         32'h0000_0001, 1'b0, "R6"},
    '{3'd3, 2'd0, 3'd3, 3'd0, 2'd1, 1'b0, 32'h0,         32'h0000_0001, 1'b1, "R6"},
    '{3'd4, 2'd2, 3'd5, 3'd2, 2'd2, 1'b0, 32'h0,         32'hFFFF_FFFE, 1'b1, "R5"}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [2:0] op, input logic [1:0] f,
                        input logic [2:0] d, input logic [2:0] m, input logic [1:0] sz,
                        input logic sp, input logic [31:0] wd);
    @(negedge clk);
    op_valid_i = v; op_i = op; file_i = f; dst_sel_i = d; mod_sel_i = m;
    size_i = sz; suppress_i = sp; wdata_i = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid_i = 1'b0; op_i = 3'd0;
    @(posedge clk);
    #1;
  endtask

  task automatic rb(input logic [1:0] f, input logic [2:0] s, output logic [31:0] v);
    rd_file_i = f; rd_sel_i = s;
    #0.5;
    v = rdata_o;
  endtask

  task automatic chk_all_zero(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin rb(2'd0, 3'(i), v); chk(tag, v, 32'h0); end
    for (int i = 0; i < 4; i++) begin rb(2'd1, 3'(i), v); chk(tag, v, 32'h0); end
    for (int i = 0; i < 6; i++) begin rb(2'd2, 3'(i), v); chk(tag, v, 32'h0); end
    chk(tag, {31'h0, align_exc_o}, 32'h0);
    chk(tag, addr_o, 32'h0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk_all_zero("R1 initial reset");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run_op(1'b1, VEC[k].op, VEC[k].fl, VEC[k].dst, VEC[k].md, VEC[k].sz, VEC[k].sp, VEC[k].wd);
      chk($sformatf("%s vec%0d addr", VEC[k].tag, k), addr_o, VEC[k].exp_addr);
      chk($sformatf("%s vec%0d exc", VEC[k].tag, k), {31'h0, align_exc_o}, {31'h0, VEC[k].exp_exc});
    end

    // exception is a single-cycle pulse
    idle();
    chk("R7 pulse ends", {31'h0, align_exc_o}, 32'h0);

    rb(2'd0, 3'd0, v); chk("R7 update despite exception", v, 32'h1000_0004);
    rb(2'd2, 3'd2, v); chk("R4 pointer step", v, 32'h2000_0000);
    rb(2'd0, 3'd3, v); chk("R3 index wrap", v, 32'h0000_0001);
    rb(2'd2, 3'd5, v); chk("R5 post-modify sum", v, 32'h1FFF_FFFE);
    rb(2'd1, 3'd1, v); chk("R2 modifier readback", v, 32'h0000_0003);
    rb(2'd3, 3'd0, v); chk("R2 no-file readback", v, 32'h0);
    rb(2'd2, 3'd7, v); chk("R2 out-of-range readback", v, 32'h0);

    // pointer stepped by itself
    run_op(1'b1, 3'd1, 2'd2, 3'd1, 3'd0, 2'd0, 1'b0, 32'h0000_0003);
    run_op(1'b1, 3'd2, 2'd2, 3'd1, 3'd1, 2'd0, 1'b0, 32'h0);
    rb(2'd2, 3'd1, v); chk("R4 self step", v, 32'h0000_0006);

    // R10 ignored operations
    run_op(1'b1, 3'd1, 2'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0000_0005);
    run_op(1'b1, 3'd2, 2'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0);
    rb(2'd1, 3'd0, v); chk("R10 modify on modifier file", v, 32'h0000_0005);
    run_op(1'b1, 3'd3, 2'd2, 3'd6, 3'd0, 2'd2, 1'b0, 32'h0);
    chk("R10 bad select addr", addr_o, 32'hFFFF_FFFE);
    chk("R10 bad select exc", {31'h0, align_exc_o}, 32'h0);
    run_op(1'b0, 3'd1, 2'd0, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0);
    rb(2'd0, 3'd0, v); chk("R10 invalid write", v, 32'h1000_0004);
    run_op(1'b1, 3'd2, 2'd2, 3'd1, 3'd7, 2'd0, 1'b0, 32'h0);
    rb(2'd2, 3'd1, v); chk("R10 bad modifier select", v, 32'h0000_0006);
    run_op(1'b1, 3'd7, 2'd0, 3'd0, 3'd0, 2'd2, 1'b0, 32'h0);
    chk("R10 unused opcode exc", {31'h0, align_exc_o}, 32'h0);
    rb(2'd0, 3'd0, v); chk("R10 unused opcode reg", v, 32'h1000_0004);

    // reset mid-run after a misaligned access
    run_op(1'b1, 3'd3, 2'd0, 3'd3, 3'd0, 2'd2, 1'b0, 32'h0);
    chk("R6 word at odd address", {31'h0, align_exc_o}, 32'h1);
    @(negedge clk);
    op_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk_all_zero("R1 reset mid-run");
    @(negedge clk);
    rst_ni = 1'b1;
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule